// File: doc/BRIEF.md
# PS/2 Scan Code Reader

This block receives keyboard traffic on the two open-collector lines of a PS/2 port and turns it into scan codes for downstream key decoding. Both lines are brought into the system clock domain through synchroniser flops. The clock line is then edge-detected, and an 11-bit frame is assembled one bit per keyboard clock pulse. The frame carries a start bit, eight data bits with the least significant first, a parity bit and a stop bit. The eight data bits become the frame's byte.

A sequencer above the frame receiver tracks a whole key event across several frames. The first frame of an event is taken as the make code and raises a one-cycle key-valid strobe. The second frame is stored in its own register. If it is the break prefix 0xF0, a third frame is read that repeats the key's code, and a one-cycle release strobe is raised. The sequencer then waits for the next key press. The three captured bytes stay on the outputs until they are overwritten. Parity is not checked, and the block never drives the lines.

Top module: `kbd_scan_reader`

## Requirements
- R1: After reset all three code outputs are 0x00 and both strobes are low.
- R2: A frame begins only when the receiver has seen both synchronised lines high and data then falls while clock is still high. A data-low period that begins while clock is low does not start a frame. Clock pulses made during such a period capture nothing.
- R3: Each frame is 11 bits, with each bit sampled on a falling edge of the keyboard clock. The byte is made of frame bits 1 to 8, with frame bit 1 as byte bit 0 (least significant first). Bit 0 is start (0), bit 9 is parity and bit 10 is stop (1).
- R4: Keyboard clock pulses with the data line held high while the receiver is idle capture nothing. They change no output and raise no strobe.
- R5: The first frame of a key event is written to `make_code_o`, and `key_valid_o` is high for exactly one cycle.
- R6: The second frame is written to `second_code_o`. If it equals 0xF0, the next frame is written to `third_code_o` and `key_release_o` is high for exactly one cycle. `make_code_o` is left unchanged and no key-valid strobe is raised during the break sequence.
- R7: A second frame other than 0xF0 is written to `second_code_o`. It is also treated as a new make code: it is written to `make_code_o` with a key-valid strobe, and the sequencer keeps waiting for a possible break prefix.
- R8: After the third frame of a break sequence, the next frame is treated as the first frame of a new key event.
- R9: A frame with wrong parity is accepted like any other frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous |
| make_code_o | output | 8 | First captured byte (make code) |
| second_code_o | output | 8 | Second captured byte |
| third_code_o | output | 8 | Third captured byte (code after the break prefix) |
| key_valid_o | output | 1 | One-cycle strobe when a make code is captured |
| key_release_o | output | 1 | One-cycle strobe when a break sequence completes |

## Verification
The assertions take for granted that the keyboard obeys its framing rules. This means a low start bit and a high stop bit, with data changed only while clock is high and held stable across each falling edge. Each clock half-period must also span several system cycles more than the synchroniser latency. The stimulus keeps within these rules by holding every keyboard clock phase for eight system cycles and changing data at the start of a high phase. It leaves a long idle gap with both lines high between frames. The only deliberate departures are the idle-clock and low-data-while-clock-low episodes. In those episodes no frame is captured, so the framing assertion is never reached.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

  localparam int unsigned KB_FRAME_BITS = 11;
  localparam int unsigned KB_CODE_W     = 8;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_ARMED,
    FR_LOW,
    FR_HIGH
  } fr_state_e;

  typedef enum logic [1:0] {
    SQ_MAKE,
    SQ_NEXT,
    SQ_REL
  } sq_state_e;

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kclk_i,
  input  logic kdat_i,
  output logic kclk_o,
  output logic kdat_o,
  output logic fall_o,
  output logic rise_o
);

  localparam int unsigned LINES = 2;

  logic [LINES-1:0]             line_in;
  logic [LINES-1:0][STAGES-1:0] pipe_q;
  logic                         clk_last_q;

  assign line_in = {kdat_i, kclk_i};

  // Idle bus level is high, so the pipes reset to ones.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q     <= '1;
      clk_last_q <= 1'b1;
    end else begin
      for (int l = 0; l < int'(LINES); l++) begin
        pipe_q[l] <= {pipe_q[l][STAGES-2:0], line_in[l]};
      end
      clk_last_q <= pipe_q[0][STAGES-1];
    end
  end

  assign kclk_o = pipe_q[0][STAGES-1];
  assign kdat_o = pipe_q[1][STAGES-1];
  assign fall_o = clk_last_q & ~kclk_o;
  assign rise_o = ~clk_last_q & kclk_o;

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_pkg::*;
#(
  parameter int unsigned FRAME_BITS = KB_FRAME_BITS,
  parameter int unsigned CODE_W     = KB_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kclk_i,
  input  logic              kdat_i,
  input  logic              fall_i,
  input  logic              rise_i,
  output logic              done_o,
  output logic [CODE_W-1:0] byte_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  fr_state_e             st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  cnt_en;
  logic [FRAME_BITS-1:0] shf_q;
  logic                  shf_en;
  logic                  done_d, done_q;
  logic [CODE_W-1:0]     byte_q;
  logic                  last_bit;
  logic                  frame_unused;

  assign last_bit = (cnt_q == CNT_W'(FRAME_BITS - 1));

  // Next-state logic: one falling then one rising clock edge per bit.
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    shf_en = 1'b0;
    done_d = 1'b0;
    case (st_q)
      FR_IDLE: begin
        if (kclk_i && kdat_i) st_d = FR_ARMED;
      end
      FR_ARMED: begin
        if (!kclk_i) begin
          st_d = FR_IDLE;
        end else if (!kdat_i) begin
          st_d   = FR_LOW;
          cnt_en = 1'b1;
          cnt_d  = '0;
        end
      end
      FR_LOW: begin
        if (fall_i) begin
          shf_en = 1'b1;
          st_d   = FR_HIGH;
        end
      end
      FR_HIGH: begin
        if (rise_i) begin
          cnt_en = 1'b1;
          if (last_bit) begin
            cnt_d  = '0;
            done_d = 1'b1;
            st_d   = FR_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
            st_d  = FR_LOW;
          end
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      shf_q  <= '0;
      done_q <= 1'b0;
      byte_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
      // Least significant bit arrives first: shift toward bit 0.
      if (shf_en) shf_q <= {kdat_i, shf_q[FRAME_BITS-1:1]};
      if (done_d) byte_q <= shf_q[CODE_W:1];
    end
  end

  // Start, parity and stop positions are carried but not decoded.
  assign frame_unused = ^{shf_q[0], shf_q[FRAME_BITS-1:CODE_W+1]};

  assign done_o = done_q;
  assign byte_o = byte_q;

  // R3: a frame is only reported after a rising keyboard clock edge.
  p_done_on_rise_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(rise_i));

  // R3: the bit counter never passes the frame length.
  p_cnt_range_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(FRAME_BITS));

  // R3: a completed frame holds a low start bit and a high stop bit.
  p_frame_marks_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_d |-> (!shf_q[0] && shf_q[FRAME_BITS-1]));

endmodule

// File: rtl/kbd_code_seq.sv
module kbd_code_seq
  import kbd_pkg::*;
#(
  parameter int unsigned       CODE_W     = KB_CODE_W,
  parameter logic [CODE_W-1:0] BREAK_CODE = 'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CODE_W-1:0] byte_i,
  output logic [CODE_W-1:0] code1_o,
  output logic [CODE_W-1:0] code2_o,
  output logic [CODE_W-1:0] code3_o,
  output logic              valid_o,
  output logic              release_o
);

  sq_state_e         st_q, st_d;
  logic              wr1, wr2, wr3;
  logic              valid_d, valid_q;
  logic              rel_d, rel_q;
  logic [CODE_W-1:0] code1_q, code2_q, code3_q;
  logic              is_break;

  assign is_break = (byte_i == BREAK_CODE);

  always_comb begin
    st_d    = st_q;
    wr1     = 1'b0;
    wr2     = 1'b0;
    wr3     = 1'b0;
    valid_d = 1'b0;
    rel_d   = 1'b0;
    if (done_i) begin
      case (st_q)
        SQ_MAKE: begin
          wr1     = 1'b1;
          valid_d = 1'b1;
          st_d    = SQ_NEXT;
        end
        SQ_NEXT: begin
          wr2 = 1'b1;
          if (is_break) begin
            st_d = SQ_REL;
          end else begin
            wr1     = 1'b1;
            valid_d = 1'b1;
          end
        end
        SQ_REL: begin
          wr3   = 1'b1;
          rel_d = 1'b1;
          st_d  = SQ_MAKE;
        end
        default: st_d = SQ_MAKE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_MAKE;
      valid_q <= 1'b0;
      rel_q   <= 1'b0;
      code1_q <= '0;
      code2_q <= '0;
      code3_q <= '0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      rel_q   <= rel_d;
      if (wr1) code1_q <= byte_i;
      if (wr2) code2_q <= byte_i;
      if (wr3) code3_q <= byte_i;
    end
  end

  assign code1_o   = code1_q;
  assign code2_o   = code2_q;
  assign code3_o   = code3_q;
  assign valid_o   = valid_q;
  assign release_o = rel_q;

  // R5: the key-valid strobe lasts a single cycle.
  p_valid_pulse_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R6: make and release are never reported together.
  p_strobe_excl_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && rel_q));

  // R6: a release is only reported once the break prefix was stored.
  p_release_brk_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> (code2_q == BREAK_CODE));

  // R6: completing a break sequence leaves the make code alone.
  p_release_keeps_make_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> $stable(code1_q));

endmodule

// File: rtl/kbd_scan_reader.sv
module kbd_scan_reader
  import kbd_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       FRAME_BITS  = KB_FRAME_BITS,
  parameter int unsigned       CODE_W      = KB_CODE_W,
  parameter logic [CODE_W-1:0] BREAK_CODE  = 'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kb_clk_i,
  input  logic              kb_dat_i,
  output logic [CODE_W-1:0] make_code_o,
  output logic [CODE_W-1:0] second_code_o,
  output logic [CODE_W-1:0] third_code_o,
  output logic              key_valid_o,
  output logic              key_release_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              kclk_s, kdat_s, kfall, krise;
  logic              frame_done;
  logic [CODE_W-1:0] frame_byte;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  kbd_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .kclk_i (kb_clk_i),
    .kdat_i (kb_dat_i),
    .kclk_o (kclk_s),
    .kdat_o (kdat_s),
    .fall_o (kfall),
    .rise_o (krise)
  );

  kbd_frame_rx #(
    .FRAME_BITS (FRAME_BITS),
    .CODE_W     (CODE_W)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .kclk_i (kclk_s),
    .kdat_i (kdat_s),
    .fall_i (kfall),
    .rise_i (krise),
    .done_o (frame_done),
    .byte_o (frame_byte)
  );

  kbd_code_seq #(
    .CODE_W     (CODE_W),
    .BREAK_CODE (BREAK_CODE)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .done_i    (frame_done),
    .byte_i    (frame_byte),
    .code1_o   (make_code_o),
    .code2_o   (second_code_o),
    .code3_o   (third_code_o),
    .valid_o   (key_valid_o),
    .release_o (key_release_o)
  );

endmodule

// File: tb/sim_kbd_scan_reader.sv
`timescale 1ns/1ps
module sim_kbd_scan_reader;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       kc, kd;
  logic [7:0] mk, c2, c3;
  logic       kv, kr;

  int  nchk = 0;
  int  nfail = 0;
  int  nv = 0;
  int  nr = 0;
  bit  kv_prev = 1'b0;
  bit  kr_prev = 1'b0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  kbd_scan_reader u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .kb_clk_i      (kc),
    .kb_dat_i      (kd),
    .make_code_o   (mk),
    .second_code_o (c2),
    .third_code_o  (c3),
    .key_valid_o   (kv),
    .key_release_o (kr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe counting and single-cycle width (R5, R6).
  always @(negedge clk) begin
    if (rst_n) begin
      if (kv) nv++;
      if (kr) nr++;
      if (kv && kv_prev) chk(1'b0, "R5 key_valid width", 2, 1);
      if (kr && kr_prev) chk(1'b0, "R6 key_release width", 2, 1);
      kv_prev = kv;
      kr_prev = kr;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit badpar);
    logic [10:0] f;
    f = {1'b1, (~^b) ^ badpar, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      kd = f[i];
      wait_n(H);
      kc = 1'b0;
      wait_n(H);
      kc = 1'b1;
    end
    wait_n(H);
    kd = 1'b1;
    wait_n(4 * H);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v0, r0;
    kc = 1'b1;
    kd = 1'b1;
    rst_n = 1'b0;
    wait_n(10);
    rst_n = 1'b1;
    wait_n(6);

    // R1: reset state
    chk(mk == 8'h00, "R1 make_code", mk, 0);
    chk(c2 == 8'h00, "R1 second_code", c2, 0);
    chk(c3 == 8'h00, "R1 third_code", c3, 0);
    chk(!kv && !kr, "R1 strobes", {kv, kr}, 0);

    // R4: idle clock pulses with data high
    for (int p = 0; p < 5; p++) begin
      kc = 1'b0; wait_n(H);
      kc = 1'b1; wait_n(H);
    end
    wait_n(4 * H);
    chk(nv == 0 && nr == 0, "R4 strobes after idle clocks", nv + nr, 0);
    chk(mk == 8'h00, "R4 make_code after idle clocks", mk, 0);

    // R3 R5 R6 R8: sweep of key codes through full make/break events
    for (int k = 0; k < 256; k += 3) begin
      v0 = nv;
      r0 = nr;
      send_frame(8'(k), 1'b0);
      chk(nv == v0 + 1, "R5 R8 key_valid count", nv, v0 + 1);
      chk(mk == 8'(k), "R3 make_code value", mk, k);
      send_frame(8'hF0, 1'b0);
      chk(c2 == 8'hF0, "R6 second_code break", c2, 8'hF0);
      chk(nv == v0 + 1 && nr == r0, "R6 no strobe on prefix", nv, v0 + 1);
      send_frame(8'(k), 1'b0);
      chk(nr == r0 + 1, "R6 key_release count", nr, r0 + 1);
      chk(c3 == 8'(k), "R6 third_code value", c3, k);
      chk(mk == 8'(k) && nv == v0 + 1, "R6 make_code held", mk, k);
    end

    // R7: second frame not the break prefix
    v0 = nv;
    r0 = nr;
    send_frame(8'h1C, 1'b0);
    send_frame(8'h32, 1'b0);
    chk(nv == v0 + 2, "R7 key_valid count", nv, v0 + 2);
    chk(mk == 8'h32, "R7 make_code", mk, 8'h32);
    chk(c2 == 8'h32, "R7 second_code", c2, 8'h32);
    chk(nr == r0, "R7 no release", nr, r0);
    send_frame(8'hF0, 1'b0);
    send_frame(8'h32, 1'b0);
    chk(nr == r0 + 1 && c3 == 8'h32, "R7 release after repeat", c3, 8'h32);

    // R9: parity errors are ignored
    v0 = nv;
    r0 = nr;
    send_frame(8'h5A, 1'b1);
    chk(nv == v0 + 1 && mk == 8'h5A, "R9 make with bad parity", mk, 8'h5A);
    send_frame(8'hF0, 1'b1);
    send_frame(8'h5A, 1'b1);
    chk(nr == r0 + 1 && c3 == 8'h5A, "R9 release with bad parity", c3, 8'h5A);

    // R2: data going low while clock is low does not start a frame
    v0 = nv;
    r0 = nr;
    kc = 1'b0; wait_n(H);
    kd = 1'b0; wait_n(H);
    kc = 1'b1; wait_n(H);
    for (int p = 0; p < 3; p++) begin
      kc = 1'b0; wait_n(H);
      kc = 1'b1; wait_n(H);
    end
    kd = 1'b1;
    wait_n(4 * H);
    chk(nv == v0 && nr == r0, "R2 no frame from bad start", nv, v0);
    chk(mk == 8'h5A, "R2 make_code untouched", mk, 8'h5A);
    send_frame(8'h33, 1'b0);
    chk(nv == v0 + 1 && mk == 8'h33, "R2 clean frame after bad start", mk, 8'h33);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule